// File: doc/BRIEF.md
# Condition-Code Flag Update Unit

This unit holds the 8-bit condition-code register of a CPU datapath and computes the arithmetic flags for operands of byte, word or long size. Each cycle it may take one operation: an add, an add with carry-in, a subtract, a subtract with borrow-in, a compare or a negate. It forms the result at the chosen size and updates the half-carry, negative, zero, overflow and carry flags. The register can also be loaded as a whole, or combined with an 8-bit immediate by AND, OR or XOR. Its current value is always visible on an output, so software can read it back.

The top bit of the register is an interrupt mask. Exception entry forces the mask to 1. A registered accept output then lets an ordinary interrupt request through only while the mask is clear, and it always lets a non-maskable request through. The half-carry bit is the carry or borrow out of bit 3 for bytes, bit 11 for words and bit 27 for longs. Compare updates the flags and leaves the result register as it was.

Top module: `ccr_unit`

## Requirements
- R1: A synchronous active-high reset sets the register to 0x80, with the mask set and every other bit 0. It also clears the result register and the accept output.
- R2: The bit layout is: bit 7 mask, bit 6 user flag A, bit 5 half-carry, bit 4 user flag B, bit 3 negative, bit 2 zero, bit 1 overflow, bit 0 carry. For a byte add (op 1), half-carry is the carry out of bit 3 and carry is the carry out of bit 7. Overflow is signed overflow, negative is result bit 7, and zero is set when the 8-bit result is 0.
- R3: The size code is 0 for byte, 1 for word and 2 or 3 for long. Half-carry is taken from bit 11 for words and bit 27 for longs. Negative is the top bit at the chosen size. Result bits above that size read 0.
- R4: Subtract (op 3) and compare (op 5) compute A minus B. Carry and half-carry show a borrow. Compare updates the flags and leaves the result register unchanged.
- R5: Add with carry (op 2) adds the current carry flag. Subtract with borrow (op 4) also subtracts the current carry flag.
- R6: Negate (op 6) computes 0 minus operand A, with flags as for a subtract.
- R7: The arithmetic ops 1 to 6 leave the mask and both user bits unchanged.
- R8: Load (op 7) writes the immediate into the whole register. Ops 8, 9 and 10 replace the register with its AND, OR or XOR with the immediate.
- R9: Exception entry sets the mask on the next edge. This wins over a same-cycle operation that would clear the mask.
- R10: The accept output registers (NMI or (IRQ and mask clear)), using the mask in the register at that edge. User flag A has no effect on it.
- R11: When op_valid is low, or the op is 0, the register and the result do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (0 none, 1 to 10 as in R2 to R8) |
| op_size | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 long |
| opnd_a | input | 32 | First operand (the operand for negate) |
| opnd_b | input | 32 | Second operand |
| cc_imm | input | 8 | Immediate for load, AND, OR and XOR |
| exc_entry | input | 1 | Exception sequence starts this cycle |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| ccr_q | output | 8 | Condition-code register |
| result_q | output | 32 | Registered arithmetic result, zero-extended |
| irq_accept | output | 1 | Registered interrupt accept |

## Verification
Two things can write the mask bit in the same cycle: exception entry, and a register load or AND that would clear the mask. The bench issues a load of 0x00 and an AND with 0x7F in the same cycle as exception entry. It then expects the mask to read 1 while every other bit follows the operation. Mask changes and interrupt gating also meet: an interrupt request is held across a load that clears the mask. The accept output is judged against the mask value that was present at each edge, with user flag A set to show that it plays no part.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int CCR_W  = 8;
  localparam int BIT_I  = 7;
  localparam int BIT_H  = 5;
  localparam int BIT_N  = 3;
  localparam int BIT_Z  = 2;
  localparam int BIT_V  = 1;
  localparam int BIT_C  = 0;
  localparam logic [CCR_W-1:0] CCR_RST = 8'h80;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_ADD    = 4'd1,
    OP_ADDC   = 4'd2,
    OP_SUB    = 4'd3,
    OP_SUBB   = 4'd4,
    OP_CMP    = 4'd5,
    OP_NEG    = 4'd6,
    OP_LOADCC = 4'd7,
    OP_ANDCC  = 4'd8,
    OP_ORCC   = 4'd9,
    OP_XORCC  = 4'd10
  } cc_op_e;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } arith_flags_t;

  function automatic logic is_arith(cc_op_e o);
    return (o == OP_ADD) || (o == OP_ADDC) || (o == OP_SUB) ||
           (o == OP_SUBB) || (o == OP_CMP) || (o == OP_NEG);
  endfunction

  function automatic logic writes_result(cc_op_e o);
    return is_arith(o) && (o != OP_CMP);
  endfunction
endpackage

// File: rtl/ccr_alu.sv
module ccr_alu
  import ccr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  parameter int HC_OFS = 4
) (
  input  cc_op_e              op,
  input  logic [1:0]          size,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic                c_in,
  output logic [DATA_W-1:0]   res,
  output arith_flags_t        flags
);
  localparam int SUM_W = DATA_W + 1;
  localparam int IDX_W = $clog2(SUM_W + 1);

  logic [IDX_W-1:0]  width;
  logic [DATA_W-1:0] mask, x, y, y_raw;
  logic [SUM_W-1:0]  sum, carries;
  logic              is_sub, ci;

  always_comb begin
    case (size)
      2'd0:    width = IDX_W'(BYTE_W);
      2'd1:    width = IDX_W'(WORD_W);
      default: width = IDX_W'(DATA_W);
    endcase
    mask   = {DATA_W{1'b1}} >> (IDX_W'(DATA_W) - width);
    is_sub = (op == OP_SUB) || (op == OP_SUBB) || (op == OP_CMP) || (op == OP_NEG);
    case (op)
      OP_ADDC:                 ci = c_in;
      OP_SUBB:                 ci = ~c_in;
      OP_SUB, OP_CMP, OP_NEG:  ci = 1'b1;
      default:                 ci = 1'b0;
    endcase
    // negate is evaluated as zero minus operand A
    x       = (op == OP_NEG) ? '0 : (a & mask);
    y_raw   = (op == OP_NEG) ? a : b;
    y       = (is_sub ? ~y_raw : y_raw) & mask;
    sum     = {1'b0, x} + {1'b0, y} + SUM_W'(ci);
    // carries[j] is the carry into bit j
    carries = sum ^ {1'b0, x} ^ {1'b0, y};
    res     = sum[DATA_W-1:0] & mask;
    flags.n = sum[width - 1'b1];
    flags.z = (res == '0);
    flags.v = carries[width] ^ carries[width - 1'b1];
    flags.c = carries[width] ^ is_sub;
    flags.h = carries[width - IDX_W'(HC_OFS)] ^ is_sub;
  end
endmodule

// File: rtl/ccr_reg.sv
module ccr_reg
  import ccr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  cc_op_e           op,
  input  logic [CCR_W-1:0] imm,
  input  arith_flags_t     flags,
  input  logic             exc_entry,
  output logic [CCR_W-1:0] ccr_q
);
  logic [CCR_W-1:0] ccr_d;

  always_comb begin
    ccr_d = ccr_q;
    if (op_valid) begin
      case (op)
        OP_LOADCC: ccr_d = imm;
        OP_ANDCC:  ccr_d = ccr_q & imm;
        OP_ORCC:   ccr_d = ccr_q | imm;
        OP_XORCC:  ccr_d = ccr_q ^ imm;
        default: begin
          if (is_arith(op)) begin
            ccr_d[BIT_H] = flags.h;
            ccr_d[BIT_N] = flags.n;
            ccr_d[BIT_Z] = flags.z;
            ccr_d[BIT_V] = flags.v;
            ccr_d[BIT_C] = flags.c;
          end
        end
      endcase
    end
    // exception entry overrides any same-cycle write of the mask
    if (exc_entry) ccr_d[BIT_I] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ccr_q <= CCR_RST;
    else     ccr_q <= ccr_d;
  end

  assert_exc_sets_mask_R9: assert property (@(posedge clk) disable iff (rst)
    exc_entry |=> ccr_q[BIT_I]);

  assert_user_bits_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_arith(op) && !exc_entry) |=>
      (ccr_q[7:6] == $past(ccr_q[7:6])) && (ccr_q[4] == $past(ccr_q[4])));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!exc_entry && (!op_valid || op == OP_NOP)) |=> $stable(ccr_q));
endmodule

// File: rtl/ccr_irq_gate.sv
module ccr_irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic mask,
  input  logic irq_req,
  input  logic nmi_req,
  output logic accept_q
);
  always_ff @(posedge clk) begin
    if (rst) accept_q <= 1'b0;
    else     accept_q <= nmi_req | (irq_req & ~mask);
  end

  assert_nmi_accept_R10: assert property (@(posedge clk) disable iff (rst)
    nmi_req |=> accept_q);

  assert_mask_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    (!nmi_req && mask) |=> !accept_q);
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  parameter int HC_OFS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [1:0]        op_size,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [7:0]        cc_imm,
  input  logic              exc_entry,
  input  logic              irq_req,
  input  logic              nmi_req,
  output logic [7:0]        ccr_q,
  output logic [DATA_W-1:0] result_q,
  output logic              irq_accept
);
  cc_op_e            op;
  logic [DATA_W-1:0] alu_res;
  arith_flags_t      alu_flags;

  assign op = cc_op_e'(op_code);

  ccr_alu #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .WORD_W(WORD_W), .HC_OFS(HC_OFS)) u_alu (
    .op(op), .size(op_size), .a(opnd_a), .b(opnd_b), .c_in(ccr_q[BIT_C]),
    .res(alu_res), .flags(alu_flags)
  );

  ccr_reg u_reg (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .imm(cc_imm),
    .flags(alu_flags), .exc_entry(exc_entry), .ccr_q(ccr_q)
  );

  ccr_irq_gate u_gate (
    .clk(clk), .rst(rst), .mask(ccr_q[BIT_I]), .irq_req(irq_req),
    .nmi_req(nmi_req), .accept_q(irq_accept)
  );

  always_ff @(posedge clk) begin
    if (rst)                                 result_q <= '0;
    else if (op_valid && writes_result(op))  result_q <= alu_res;
  end

  assert_cmp_keeps_result_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_CMP) |=> $stable(result_q));
endmodule

// File: tb/ccr_unit_tb.sv
module ccr_unit_tb;
  import ccr_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  sz;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic [4:0]  fl;   // h n z v c
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{OP_ADD, 2'd0, 32'h0F,        32'h01,        32'h10,        5'b10000},
    '{OP_ADD, 2'd0, 32'h7F,        32'h01,        32'h80,        5'b11010},
    '{OP_ADD, 2'd0, 32'hFF,        32'h01,        32'h00,        5'b10101},
    '{OP_SUB, 2'd0, 32'h10,        32'h01,        32'h0F,        5'b10000},
    '{OP_SUB, 2'd0, 32'h00,        32'h01,        32'hFF,        5'b11001},
    '{OP_SUB, 2'd0, 32'h80,        32'h01,        32'h7F,        5'b10010},
    '{OP_ADD, 2'd1, 32'h0800,      32'h0800,      32'h1000,      5'b10000},
    '{OP_ADD, 2'd1, 32'h000F,      32'h0001,      32'h0010,      5'b00000},
    '{OP_ADD, 2'd2, 32'h0800_0000, 32'h0800_0000, 32'h1000_0000, 5'b10000},
    '{OP_CMP, 2'd1, 32'h1234,      32'h1234,      32'h1000_0000, 5'b00100},
    '{OP_CMP, 2'd0, 32'h05,        32'h07,        32'h1000_0000, 5'b11001},
    '{OP_ADD, 2'd3, 32'hFFFF_FFFF, 32'h1,         32'h0,         5'b10101},
    '{OP_ADD, 2'd0, 32'h1234_56F0, 32'h10,        32'h0,         5'b00101},
    '{OP_NEG, 2'd0, 32'h01,        32'h0,         32'hFF,        5'b11001},
    '{OP_NEG, 2'd0, 32'h80,        32'h0,         32'h80,        5'b01011},
    '{OP_NEG, 2'd1, 32'h0,         32'h0,         32'h0,         5'b00100},
    '{OP_SUB, 2'd2, 32'h8000_0000, 32'h1,         32'h7FFF_FFFF, 5'b10010}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [1:0]  op_size = 2'd0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [7:0]  cc_imm = '0;
  logic        exc_entry = 1'b0, irq_req = 1'b0, nmi_req = 1'b0;
  logic [7:0]  ccr_q;
  logic [31:0] result_q;
  logic        irq_accept;
  int          n_checks = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccr_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_size(op_size),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .cc_imm(cc_imm), .exc_entry(exc_entry),
    .irq_req(irq_req), .nmi_req(nmi_req), .ccr_q(ccr_q), .result_q(result_q),
    .irq_accept(irq_accept)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge, after one posedge
  task automatic do_op(input logic v, input logic [3:0] op, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [7:0] imm, input logic exc);
    op_valid = v; op_code = op; op_size = sz; opnd_a = a; opnd_b = b;
    cc_imm = imm; exc_entry = exc;
    @(negedge clk);
    op_valid = 1'b0; op_code = 4'd0; exc_entry = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL R11 watchdog act=hung exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 ccr", 32'(ccr_q), 32'h80);
    chk("R1 result", result_q, 32'h0);
    chk("R1 accept", 32'(irq_accept), 32'h0);

    // table: mask and both user bits set, kept through arithmetic (R7)
    do_op(1'b1, OP_LOADCC, 2'd0, 0, 0, 8'hD0, 1'b0);
    for (int i = 0; i < NV; i++) begin
      do_op(1'b1, VECS[i].op, VECS[i].sz, VECS[i].a, VECS[i].b, 8'h00, 1'b0);
      chk($sformatf("R2/R3/R4/R6 result vec %0d", i), result_q, VECS[i].res);
      chk($sformatf("R2/R3/R4/R6 flags vec %0d", i),
          32'({ccr_q[5], ccr_q[3:0]}), 32'(VECS[i].fl));
      chk($sformatf("R7 user bits vec %0d", i), 32'(ccr_q & 8'hD0), 32'hD0);
    end

    // R5 carry-in and borrow-in
    do_op(1'b1, OP_LOADCC, 2'd0, 0, 0, 8'h01, 1'b0);
    do_op(1'b1, OP_ADDC, 2'd0, 32'h10, 32'h20, 8'h00, 1'b0);
    chk("R5 addc result", result_q, 32'h31);
    chk("R5 addc ccr", 32'(ccr_q), 32'h00);
    do_op(1'b1, OP_LOADCC, 2'd0, 0, 0, 8'h01, 1'b0);
    do_op(1'b1, OP_SUBB, 2'd0, 32'h31, 32'h01, 8'h00, 1'b0);
    chk("R5 subb result", result_q, 32'h2F);
    chk("R5 subb ccr", 32'(ccr_q), 32'h20);
    do_op(1'b1, OP_LOADCC, 2'd0, 0, 0, 8'h00, 1'b0);
    do_op(1'b1, OP_SUBB, 2'd0, 32'h31, 32'h01, 8'h00, 1'b0);
    chk("R5 subb no borrow result", result_q, 32'h30);
    chk("R5 subb no borrow ccr", 32'(ccr_q), 32'h00);

    // R8 whole-register load and logic with immediate
    do_op(1'b1, OP_LOADCC, 2'd0, 0, 0, 8'h5A, 1'b0);
    chk("R8 load", 32'(ccr_q), 32'h5A);
    do_op(1'b1, OP_ANDCC, 2'd0, 0, 0, 8'h0F, 1'b0);
    chk("R8 and", 32'(ccr_q), 32'h0A);
    do_op(1'b1, OP_ORCC, 2'd0, 0, 0, 8'hC0, 1'b0);
    chk("R8 or", 32'(ccr_q), 32'hCA);
    do_op(1'b1, OP_XORCC, 2'd0, 0, 0, 8'hFF, 1'b0);
    chk("R8 xor", 32'(ccr_q), 32'h35);

    // R9 exception entry against a same-cycle write clearing the mask
    do_op(1'b1, OP_LOADCC, 2'd0, 0, 0, 8'h00, 1'b1);
    chk("R9 load with exception", 32'(ccr_q), 32'h80);
    do_op(1'b1, OP_LOADCC, 2'd0, 0, 0, 8'hFF, 1'b0);
    do_op(1'b1, OP_ANDCC, 2'd0, 0, 0, 8'h7F, 1'b1);
    chk("R9 and with exception", 32'(ccr_q), 32'hFF);
    do_op(1'b1, OP_LOADCC, 2'd0, 0, 0, 8'h01, 1'b0);
    do_op(1'b0, OP_NOP, 2'd0, 0, 0, 8'h00, 1'b1);
    chk("R9 exception alone", 32'(ccr_q), 32'h81);

    // R10 interrupt gating
    irq_req = 1'b1;
    do_op(1'b0, OP_NOP, 2'd0, 0, 0, 8'h00, 1'b0);
    chk("R10 irq masked", 32'(irq_accept), 32'h0);
    nmi_req = 1'b1;
    do_op(1'b0, OP_NOP, 2'd0, 0, 0, 8'h00, 1'b0);
    chk("R10 nmi while masked", 32'(irq_accept), 32'h1);
    nmi_req = 1'b0;
    do_op(1'b1, OP_LOADCC, 2'd0, 0, 0, 8'h40, 1'b0);
    chk("R10 mask still set at load edge", 32'(irq_accept), 32'h0);
    do_op(1'b0, OP_NOP, 2'd0, 0, 0, 8'h00, 1'b0);
    chk("R10 irq unmasked, user flag A set", 32'(irq_accept), 32'h1);
    irq_req = 1'b0;
    do_op(1'b0, OP_NOP, 2'd0, 0, 0, 8'h00, 1'b0);
    chk("R10 no request", 32'(irq_accept), 32'h0);

    // R11 idle cycles change nothing
    do_op(1'b1, OP_ADD, 2'd0, 32'h21, 32'h22, 8'h00, 1'b0);
    chk("R11 setup result", result_q, 32'h43);
    do_op(1'b0, OP_LOADCC, 2'd0, 32'h1, 32'h1, 8'hFF, 1'b0);
    chk("R11 invalid op ccr", 32'(ccr_q), 32'h40);
    do_op(1'b0, OP_ADD, 2'd0, 32'h1, 32'h1, 8'hFF, 1'b0);
    chk("R11 invalid op result", result_q, 32'h43);
    do_op(1'b1, OP_NOP, 2'd0, 32'h1, 32'h1, 8'hFF, 1'b0);
    chk("R11 nop ccr", 32'(ccr_q), 32'h40);
    chk("R11 nop result", result_q, 32'h43);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule